// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. It presents a trial code to an external DAC, reads back one comparator bit saying whether the held analog input lies above the DAC output, and runs a binary search from the most significant bit down to the least. After N decisions the code that brackets the input is left in the approximation register and copied to a separate result output.

A conversion begins when the start strobe is seen while the block is not busy. The first cycle of every conversion is spent clearing the approximation register. Each of the following N cycles decides one bit. A conversion therefore occupies N+1 clocks. The end-of-conversion flag then rises and stays high, with the result held, until the next accepted start.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high reset sets busy and eoc low and sets trial_code and result to zero. This applies on any cycle, including in the middle of a conversion.
- R2: A start strobe sampled while busy is low (idle, or finished) begins a conversion. In the next cycle busy is high, eoc is low and trial_code is zero. This is the clearing cycle.
- R3: In the cycle after the clearing cycle, trial_code has only bit N-1 set.
- R4: The comparator bit is sampled on the clock edge that ends each trial cycle. If it is 1, the bit under test stays 1. If it is 0, that bit becomes 0. In both cases the next lower bit becomes 1 in the following trial code.
- R5: A comparator reading of 0 clears the bit under test even when the analog input equals the DAC level. The input is then treated as not greater.
- R6: busy stays high for exactly N+1 consecutive cycles. In the cycle after the least significant decision, busy is low, eoc is high, and result equals the final trial_code.
- R7: eoc, result and trial_code hold their values until the next accepted start. eoc drops in the clearing cycle of the new conversion, and result reads zero from then until the new conversion finishes.
- R8: A start strobe sampled while busy is high is ignored. The running conversion keeps its trial sequence, its length and its result.
- R9: The comparator input has no effect outside trial cycles. While idle or finished, trial_code and result do not change whatever the comparator shows.
- R10: When the comparator reports an input at the centre of code T, meaning the input is above the DAC output whenever T >= trial_code, the result equals T for every T in 0..2^N-1. With N=3 and T=5 the trial codes are 100, 110, 101 and the result is 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| soc | input | 1 | Start-of-conversion strobe |
| cmp_gt | input | 1 | Comparator: 1 when the analog input is above the DAC output |
| trial_code | output | N | Code driven to the external DAC |
| result | output | N | Final converted code |
| busy | output | 1 | High from the clearing cycle through the last bit decision |
| eoc | output | 1 | End of conversion, held until the next accepted start |

## Verification
The bench builds two copies of the block. The first uses the default N=8. It is small enough that every one of the 256 target codes can be converted, with every intermediate trial code compared against a bench-side binary search. The second uses N=3, which allows the full trial sequence to be checked by hand: 100, 110, 101 for a target of 5. The same N=3 instance shows that a strict "greater than" comparator, which reads 0 on equality, yields 100 instead. Start strobes injected mid-conversion, comparator toggling after completion, and a reset in mid-search are checked on the 8-bit copy.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_TRIAL = 2'd2,
        ST_DONE  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soc,
    output logic         start_acc,
    output logic         seed,
    output logic         decide,
    output logic         last,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] mask
);

    localparam logic [N-1:0] MSB_ONE = {1'b1, {(N-1){1'b0}}};

    typedef struct packed {
        sar_state_e   st;
        logic [N-1:0] mask;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE, ST_DONE: begin
                if (soc) begin
                    seq_d.st   = ST_CLEAR;
                    seq_d.mask = '0;
                end
            end
            ST_CLEAR: begin
                seq_d.st   = ST_TRIAL;
                seq_d.mask = MSB_ONE;
            end
            ST_TRIAL: begin
                if (seq_q.mask[0]) begin
                    seq_d.st   = ST_DONE;
                    seq_d.mask = '0;
                end else begin
                    seq_d.mask = seq_q.mask >> 1;
                end
            end
            default: seq_d = '{st: ST_IDLE, mask: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_IDLE, mask: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.st == ST_CLEAR) || (seq_q.st == ST_TRIAL);
    assign done      = (seq_q.st == ST_DONE);
    assign seed      = (seq_q.st == ST_CLEAR);
    assign decide    = (seq_q.st == ST_TRIAL);
    assign last      = decide && seq_q.mask[0];
    assign start_acc = soc && !busy;
    assign mask      = seq_q.mask;

    // R3: the clearing cycle is always followed by the MSB trial
    assert_msb_follows_clear_R3: assert property (@(posedge clk) disable iff (rst)
        seed |=> (decide && mask[N-1]));

    // R4: exactly one bit under test in every trial cycle
    assert_one_bit_under_test_R4: assert property (@(posedge clk) disable iff (rst)
        decide |-> ($countones(mask) == 1));

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         seed,
    input  logic         decide,
    input  logic         cmp_gt,
    input  logic [N-1:0] mask,
    output logic [N-1:0] code_q,
    output logic [N-1:0] code_d
);

    typedef struct packed {
        logic [N-1:0] code;
    } areg_t;

    areg_t areg_d, areg_q;
    logic [N-1:0] bit_nxt;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == N - 1) begin : g_top
            assign bit_nxt[i] = clear  ? 1'b0 :
                                seed   ? 1'b1 :
                                (decide && mask[i]) ? cmp_gt :
                                areg_q.code[i];
        end else begin : g_low
            assign bit_nxt[i] = clear  ? 1'b0 :
                                seed   ? 1'b0 :
                                (decide && mask[i])   ? cmp_gt :
                                (decide && mask[i+1]) ? 1'b1   :
                                areg_q.code[i];
        end

        // R4: decided bit takes the comparator value sampled at the edge
        assert_bit_decision_R4: assert property (@(posedge clk) disable iff (rst)
            (decide && mask[i] && !clear) |=> (code_q[i] == $past(cmp_gt)));
    end

    always_comb begin
        areg_d.code = bit_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            areg_q <= '0;
        end else begin
            areg_q <= areg_d;
        end
    end

    assign code_q = areg_q.code;
    assign code_d = areg_d.code;

    // R9: with no control active the register keeps its value
    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clear && !seed && !decide) |=> $stable(code_q));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soc,
    input  logic         cmp_gt,
    output logic [N-1:0] trial_code,
    output logic [N-1:0] result,
    output logic         busy,
    output logic         eoc
);

    typedef struct packed {
        logic [N-1:0] res;
    } top_t;

    logic         start_acc, seed, decide, last, seq_busy, seq_done;
    logic [N-1:0] mask, code_q, code_d;
    top_t         top_d, top_q;

    sar_sequencer #(.N(N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .soc       (soc),
        .start_acc (start_acc),
        .seed      (seed),
        .decide    (decide),
        .last      (last),
        .busy      (seq_busy),
        .done      (seq_done),
        .mask      (mask)
    );

    sar_approx_reg #(.N(N)) u_areg (
        .clk    (clk),
        .rst    (rst),
        .clear  (start_acc),
        .seed   (seed),
        .decide (decide),
        .cmp_gt (cmp_gt),
        .mask   (mask),
        .code_q (code_q),
        .code_d (code_d)
    );

    always_comb begin
        top_d = top_q;
        if (start_acc) begin
            top_d.res = '0;
        end else if (last) begin
            top_d.res = code_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign trial_code = code_q;
    assign result     = top_q.res;
    assign busy       = seq_busy;
    assign eoc        = seq_done;

    // R1: reset clears everything
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!busy && !eoc && trial_code == '0 && result == '0));

    // R2: accepted start opens the clearing cycle
    assert_clear_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (soc && !busy) |=> (busy && !eoc && trial_code == '0));

    // R6: completion after the LSB decision
    assert_completion_R6: assert property (@(posedge clk) disable iff (rst)
        last |=> (eoc && !busy && result == trial_code));

    // R7: finished state holds until a new start
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (eoc && !soc) |=> (eoc && $stable(result) && $stable(trial_code)));

    // R8: a running conversion cannot be cut short or restarted
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> (busy && !eoc));

endmodule

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       sel3  = 1'b0;
    logic       soc_m = 1'b0;
    logic       cmp_m = 1'b0;

    logic [7:0] trial8, result8;
    logic [2:0] trial3, result3;
    logic       busy8, eoc8, busy3, eoc3;
    logic       soc8, soc3, cmp8, cmp3;
    logic [7:0] tr_m, res_m;
    logic       busy_m, eoc_m;

    assign soc8 = soc_m & ~sel3;
    assign soc3 = soc_m & sel3;
    assign cmp8 = cmp_m & ~sel3;
    assign cmp3 = cmp_m & sel3;

    always_comb begin
        tr_m   = sel3 ? {5'b0, trial3}  : trial8;
        res_m  = sel3 ? {5'b0, result3} : result8;
        busy_m = sel3 ? busy3 : busy8;
        eoc_m  = sel3 ? eoc3  : eoc8;
    end

    sar_conv_ctrl #(.N(8)) u_dut (
        .clk(clk), .rst(rst), .soc(soc8), .cmp_gt(cmp8),
        .trial_code(trial8), .result(result8), .busy(busy8), .eoc(eoc8)
    );

    sar_conv_ctrl #(.N(3)) u_dut_n3 (
        .clk(clk), .rst(rst), .soc(soc3), .cmp_gt(cmp3),
        .trial_code(trial3), .result(result3), .busy(busy3), .eoc(eoc3)
    );

    int n_total = 0;
    int n_fail  = 0;
    int trials [8];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // one conversion; strict=1 models a comparator that reads 0 on equality
    task automatic conv(input bit s3, input int target, input bit strict,
                        input int inj, output int res);
        int n;
        int expv;
        int cyc;
        int tr;
        n    = s3 ? 3 : 8;
        expv = 0;
        sel3 = s3;
        @(negedge clk);
        soc_m = 1'b1;
        @(negedge clk);
        soc_m = 1'b0;
        chk(busy_m && !eoc_m && tr_m == 0, "R2", {busy_m, eoc_m, tr_m}, 10'h200);
        cyc = 1;
        for (int b = n - 1; b >= 0; b--) begin
            @(negedge clk);
            soc_m = 1'b0;
            if (busy_m) cyc++;
            tr = expv | (1 << b);
            trials[n - 1 - b] = int'(tr_m);
            chk(int'(tr_m) == tr, (b == n - 1) ? "R3" : "R4", tr_m, tr);
            cmp_m = strict ? (target > int'(tr_m)) : (target >= int'(tr_m));
            if (strict ? (target > tr) : (target >= tr)) expv = tr;
            if (b == inj) soc_m = 1'b1;
        end
        @(negedge clk);
        soc_m = 1'b0;
        cmp_m = 1'b0;
        chk(!busy_m && eoc_m, "R6", {busy_m, eoc_m}, 2'b01);
        chk(cyc == n + 1, "R6", cyc, n + 1);
        chk(int'(res_m) == expv && int'(tr_m) == expv, "R10", res_m, expv);
        res = int'(res_m);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy8 && !eoc8 && trial8 == 0 && result8 == 0, "R1",
            {busy8, eoc8, trial8, result8}, 0);
        chk(!busy3 && !eoc3 && trial3 == 0 && result3 == 0, "R1",
            {busy3, eoc3, trial3, result3}, 0);
        rst = 1'b0;
    endtask

    task automatic t_n3_sequence();
        int r;
        conv(1'b1, 5, 1'b0, -1, r);
        chk(trials[0] == 3'b100 && trials[1] == 3'b110 && trials[2] == 3'b101,
            "R10", {trials[0][3:0], trials[1][3:0], trials[2][3:0]}, 12'h465);
        chk(r == 3'b101, "R10", r, 5);
        conv(1'b1, 7, 1'b0, -1, r);
        chk(r == 7, "R10", r, 7);
        conv(1'b1, 0, 1'b0, -1, r);
        chk(r == 0, "R10", r, 0);
    endtask

    task automatic t_equal_clears();
        int r;
        conv(1'b1, 5, 1'b1, -1, r);
        chk(trials[2] == 3'b101, "R5", trials[2], 5);
        chk(r == 3'b100, "R5", r, 4);
        conv(1'b0, 8'h80, 1'b1, -1, r);
        chk(r == 8'h7F, "R5", r, 8'h7F);
    endtask

    task automatic t_sweep();
        int r;
        for (int t = 0; t < 256; t++) begin
            conv(1'b0, t, 1'b0, -1, r);
            chk(r == t, "R10", r, t);
        end
    endtask

    task automatic t_busy_start_ignored();
        int r;
        conv(1'b0, 8'h3C, 1'b0, 5, r);
        chk(r == 8'h3C, "R8", r, 8'h3C);
        conv(1'b0, 8'hC3, 1'b0, 0, r);
        chk(r == 8'hC3, "R8", r, 8'hC3);
    endtask

    task automatic t_hold_and_restart();
        int r;
        conv(1'b0, 8'hA5, 1'b0, -1, r);
        for (int k = 0; k < 6; k++) begin
            cmp_m = k[0];
            @(negedge clk);
            chk(eoc8 && result8 == 8'hA5, "R7", {eoc8, result8}, 9'h1A5);
            chk(trial8 == 8'hA5, "R9", trial8, 8'hA5);
        end
        cmp_m = 1'b0;
        soc_m = 1'b1;
        @(negedge clk);
        soc_m = 1'b0;
        chk(!eoc8 && busy8 && result8 == 0, "R7", {eoc8, busy8, result8}, 9'h100);
        repeat (9) @(negedge clk);
        chk(eoc8 && result8 == 0, "R5", {eoc8, result8}, 9'h100);
        sel3 = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            cmp_m = ~cmp_m;
            @(negedge clk);
            chk(!busy8 && !eoc8 && trial8 == 0 && result8 == 0, "R9",
                {busy8, eoc8, trial8, result8}, 0);
        end
        cmp_m = 1'b0;
    endtask

    task automatic t_reset_mid_conversion();
        sel3 = 1'b0;
        cmp_m = 1'b1;
        soc_m = 1'b1;
        @(negedge clk);
        soc_m = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy8 && !eoc8 && trial8 == 0 && result8 == 0, "R1",
            {busy8, eoc8, trial8, result8}, 0);
        rst = 1'b0;
        cmp_m = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_n3_sequence();
        t_equal_clears();
        t_busy_start_ignored();
        t_hold_and_restart();
        t_reset_mid_conversion();
        t_sweep();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #500000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule